// File: doc/BRIEF.md
# Spill Start Integration Timing Sequencer

This block fixes the delay between the leading edge of a trigger frame header and the first integration cycle of a spill. The header receiver pulses `hdr_start` on the clock that sees the first header bit. The block latches both timing registers on that clock and begins a fixed wait of 73 clocks. The command decoder reports a spill-start command during that wait. If no command arrives, the block drops back to idle and produces no output.

After the fixed wait comes the programmed trigger delay, counted in clocks. Then `preamp_rst` is held for one clock more than the programmed reset length. On the next clock `integ_start` pulses once. With a 100 MHz clock, the total latency is 740 ns plus both register values times 10 ns.

One form of the spill command also asks for a coarse timestamp clear. That clear is issued in the same cycle as `integ_start`. A header edge that arrives while a sequence is running is dropped, and the block flags it.

Top module: `spill_start_sequencer`

## Requirements
- R1: After reset, `preamp_rst`, `integ_start`, `ts_clr` and `overlap` are all low.
- R2: Edge 0 is the clock edge that samples `hdr_start` high while idle. For an accepted spill, `integ_start` is high in the cycle after edge 74 + D + R, where D is `trig_delay` and R is `rst_len`.
- R3: For an accepted spill, `preamp_rst` is high for exactly R + 1 cycles. It first rises after edge 73 + D and falls in the cycle where `integ_start` is high.
- R4: `integ_start` is high for exactly one cycle per accepted spill.
- R5: `ts_clr` pulses once, together with `integ_start`, only when `spill_clr_ts` was high in the same cycle that `spill_cmd` was accepted. Otherwise `ts_clr` stays low.
- R6: A spill is accepted only if `spill_cmd` is sampled high on one of edges 1 to 73. A command outside that window is ignored, and `preamp_rst` and `integ_start` stay low for that header.
- R7: D and R are captured at edge 0. Changes to `trig_delay` or `rst_len` after edge 0 do not change the running sequence.
- R8: `hdr_start` sampled while a sequence is running does not restart it. In that case `overlap` is high for exactly the one cycle after that edge.
- R9: With D = 0 and R = 9, `integ_start` follows edge 83, which is 830 ns at a 10 ns clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, 10 ns in the intended system |
| rst_n | input | 1 | Active-low synchronous reset |
| hdr_start | input | 1 | One-clock pulse at the leading edge of a trigger frame header |
| spill_cmd | input | 1 | Decoded spill-start command strobe |
| spill_clr_ts | input | 1 | Qualifier sampled with `spill_cmd`: also clear the coarse timestamp |
| trig_delay | input | DLY_W | Extra delay in clocks after the fixed wait |
| rst_len | input | RST_W | Programmed preamp reset length; the pulse is one clock longer |
| preamp_rst | output | 1 | Preamp reset level |
| integ_start | output | 1 | One-clock pulse marking the first integration cycle |
| ts_clr | output | 1 | One-clock coarse timestamp clear, coincident with `integ_start` |
| overlap | output | 1 | One-clock flag: a header edge arrived during a running sequence |

## Verification
A wrong phase count moves the rise of `preamp_rst` or `integ_start` away from its exact cycle. This shows on the first accepted spill, since the bench checks positions cycle by cycle against D and R. A lost or stale command flag shows within the same frame: an expected spill produces no pulses, or an ignored one produces them. A state that fails to return to idle shows on the next header, which is then reported as an overlap instead of starting a sequence.

// File: rtl/spill_start_sequencer.sv
module spill_start_sequencer #(
  parameter int DLY_W      = 8,
  parameter int RST_W      = 8,
  parameter int FIXED_CLKS = 74
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hdr_start,
  input  logic             spill_cmd,
  input  logic             spill_clr_ts,
  input  logic [DLY_W-1:0] trig_delay,
  input  logic [RST_W-1:0] rst_len,
  output logic             preamp_rst,
  output logic             integ_start,
  output logic             ts_clr,
  output logic             overlap
);
  localparam int FIX_LOAD = FIXED_CLKS - 2;
  localparam int REG_W    = (DLY_W > RST_W) ? DLY_W : RST_W;
  localparam int FIX_W    = $clog2(FIXED_CLKS);
  localparam int CW       = (FIX_W > REG_W) ? FIX_W : REG_W;

  typedef enum logic [2:0] {S_IDLE, S_FIXED, S_DELAY, S_PRST, S_INTEG} st_t;

  st_t             st;
  logic [CW-1:0]   cnt;
  logic [DLY_W-1:0] dly_q;
  logic [RST_W-1:0] len_q;
  logic            armed, clr_q;

  wire cnt_zero = (cnt == '0);
  wire go_now   = armed | spill_cmd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      dly_q   <= '0;
      len_q   <= '0;
      armed   <= 1'b0;
      clr_q   <= 1'b0;
      overlap <= 1'b0;
    end else begin
      overlap <= hdr_start && (st != S_IDLE);
      case (st)
        S_IDLE: if (hdr_start) begin
          st    <= S_FIXED;
          cnt   <= CW'(FIX_LOAD);
          dly_q <= trig_delay;
          len_q <= rst_len;
          armed <= 1'b0;
          clr_q <= 1'b0;
        end
        S_FIXED: begin
          if (spill_cmd) begin
            armed <= 1'b1;
            clr_q <= spill_clr_ts;
          end
          if (!cnt_zero) cnt <= cnt - CW'(1);
          else if (!go_now) st <= S_IDLE;
          else if (dly_q != '0) begin
            st  <= S_DELAY;
            cnt <= CW'(dly_q) - CW'(1);
          end else begin
            st  <= S_PRST;
            cnt <= CW'(len_q);
          end
        end
        S_DELAY: begin
          if (!cnt_zero) cnt <= cnt - CW'(1);
          else begin
            st  <= S_PRST;
            cnt <= CW'(len_q);
          end
        end
        S_PRST: begin
          if (!cnt_zero) cnt <= cnt - CW'(1);
          else st <= S_INTEG;
        end
        S_INTEG: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign preamp_rst  = (st == S_PRST);
  assign integ_start = (st == S_INTEG);
  assign ts_clr      = integ_start & clr_q;

  logic [CW:0] pr_run;
  always_ff @(posedge clk) begin
    if (!rst_n) pr_run <= '0;
    else        pr_run <= preamp_rst ? pr_run + (CW+1)'(1) : '0;
  end

  // R3: reset pulse length is the captured value plus one
  a_r3_prst_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(preamp_rst) |-> (pr_run == (CW+1)'(len_q) + (CW+1)'(1)));
  // R3: reset pulse is directly followed by integration start
  a_r3_prst_then_integ: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(preamp_rst) |-> integ_start);
  // R4
  a_r4_integ_single: assert property (@(posedge clk) disable iff (!rst_n)
    integ_start |=> !integ_start);
  // R5
  a_r5_ts_with_integ: assert property (@(posedge clk) disable iff (!rst_n)
    ts_clr |-> integ_start);
  // R8
  a_r8_overlap_single: assert property (@(posedge clk) disable iff (!rst_n)
    overlap |=> !overlap || $past(hdr_start));
  a_r3_outputs_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({preamp_rst, integ_start}));
endmodule

// File: tb/tb_spill_start_sequencer.sv
module tb_spill_start_sequencer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hdr_start = 1'b0, spill_cmd = 1'b0, spill_clr_ts = 1'b0;
  logic [7:0] trig_delay = '0, rst_len = '0;
  logic preamp_rst, integ_start, ts_clr, overlap;

  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  spill_start_sequencer dut (
    .clk(clk), .rst_n(rst_n), .hdr_start(hdr_start), .spill_cmd(spill_cmd),
    .spill_clr_ts(spill_clr_ts), .trig_delay(trig_delay), .rst_len(rst_len),
    .preamp_rst(preamp_rst), .integ_start(integ_start), .ts_clr(ts_clr),
    .overlap(overlap)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_latency(input int d, input int r);
    return 74 + d + r;
  endfunction

  function automatic bit exp_accept(input int cmd_at);
    return (cmd_at >= 1) && (cmd_at <= 73);
  endfunction

  task automatic run(input int d, input int r, input int cmd_at, input bit clr,
                     input int ov_at, input bit chg);
    int lat = exp_latency(d, r);
    bit go = exp_accept(cmd_at);
    int ik = -1, in_n = 0, pf = -1, pn = 0, tn = 0, tw = 0, on_n = 0, ok_at = -1;
    trig_delay = 8'(d);
    rst_len    = 8'(r);
    for (int k = 0; k <= lat + 4; k++) begin
      @(negedge clk);
      if (k > 0) begin
        if (integ_start) begin in_n++; if (ik < 0) ik = k - 1; end
        if (preamp_rst) begin pn++; if (pf < 0) pf = k - 1; end
        if (ts_clr) begin tn++; if (integ_start) tw++; end
        if (overlap) begin on_n++; ok_at = k - 1; end
      end
      hdr_start    = (k == 0) || (ov_at > 0 && k == ov_at);
      spill_cmd    = (k == cmd_at);
      spill_clr_ts = (k == cmd_at) ? clr : 1'($urandom);
      if (k == 2 && chg) begin
        trig_delay = 8'($urandom);
        rst_len    = 8'($urandom);
      end
    end
    hdr_start = 1'b0; spill_cmd = 1'b0; spill_clr_ts = 1'b0;
    repeat (3) @(negedge clk);
    if (go) begin
      chk(ik == lat, "R2 integ_start position", ik, lat);
      chk(in_n == 1, "R4 integ_start count", in_n, 1);
      chk(pf == 73 + d, "R3 preamp_rst first cycle", pf, 73 + d);
      chk(pn == r + 1, "R3 preamp_rst length", pn, r + 1);
      chk(tn == int'(clr) && tw == int'(clr), "R5 ts_clr with integ", tn, int'(clr));
      if (chg) chk(ik == lat, "R7 captured registers", ik, lat);
    end else begin
      chk(in_n == 0 && pn == 0, "R6 ignored spill command", in_n + pn, 0);
      chk(tn == 0, "R5 no ts_clr without spill", tn, 0);
    end
    if (ov_at > 0) begin
      chk(on_n == 1, "R8 overlap count", on_n, 1);
      chk(ok_at == ov_at, "R8 overlap cycle", ok_at, ov_at);
    end else
      chk(on_n == 0, "R8 no spurious overlap", on_n, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (4) @(negedge clk);
    chk({preamp_rst, integ_start, ts_clr, overlap} == 4'b0, "R1 reset outputs",
        int'({preamp_rst, integ_start, ts_clr, overlap}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk({preamp_rst, integ_start, ts_clr, overlap} == 4'b0, "R1 idle outputs",
        int'({preamp_rst, integ_start, ts_clr, overlap}), 0);
    // R9 worked example: 83 clocks
    run(0, 9, 10, 1'b0, 0, 1'b0);
    run(0, 0, 1, 1'b1, 0, 1'b0);
    run(255, 255, 73, 1'b1, 0, 1'b0);
    run(3, 4, 0, 1'b1, 0, 1'b0);     // R6 command on edge 0 ignored
    run(3, 4, 74, 1'b1, 0, 1'b0);    // R6 command after window ignored
    run(5, 2, 20, 1'b1, 73, 1'b1);   // R8 late header, R7 register change
    run(1, 1, 0, 1'b0, 40, 1'b0);    // R8 overlap during aborted frame
    for (int i = 0; i < 40; i++) begin
      int d = int'($urandom_range(0, 255));
      int r = int'($urandom_range(0, 255));
      int c = int'($urandom_range(0, 80));
      int o = ($urandom_range(0, 2) == 0) ? int'($urandom_range(1, 60)) : 0;
      run(d, r, c, 1'($urandom), o, 1'($urandom));
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule